// File: doc/BRIEF.md
# Backlight PWM Generator with Shadowed Settings

This block produces one pulse-width-modulated output for dimming a display backlight. A prescaler divides the input clock into ticks. A period counter counts ticks, and the output is high during the first part of every period. Software sets three values: the prescaler divider, the period length and the high width. It does so through a single-cycle register port with valid, write, address and data signals. Reads return their data one cycle after the request.

The three settings are double-buffered. Writes land in shadow registers and do not change the waveform. A commit strobe snapshots the shadow settings. The snapshot replaces the running settings only at the end of the current period, so no period ever mixes old and new values. While the output is disabled, a commit takes effect at once. A direct-write mode is also provided. In that mode a write to a control word changes the running settings immediately and starts a fresh period.

Top module: `bl_pwm_top`

## Requirements
- R1: After a synchronous reset every register reads 0 and `pwm_out` is low.
- R2: The enable word (offset 0x00), the direct-mode word (0x0C) and the two control words (0x10, 0x14) read back all 32 bits exactly as written, including bits outside any field. The commit word (0x08) and unmapped offsets read 0. Read data is valid in the cycle after the request.
- R3: The divider field is bits [25:16] of the word at 0x10. One tick lasts divider+1 input clocks.
- R4: The period field is bits [11:0] of the word at 0x14. One output period lasts (period+1) ticks, which is (divider+1)*(period+1) clocks.
- R5: The high-width field is bits [28:16] of the word at 0x14. The output is high for the first high-width ticks of each period, which is (divider+1)*high-width clocks.
- R6: A high width of 0 keeps the output low for the whole period. A high width of period+1 or more keeps it high for the whole period.
- R7: Bit 0 of the enable word gates the output. When the bit is clear, the output goes low two clock edges after the write. When the bit is set, the counters start from zero and the output goes high two edges after the write, provided the high width is nonzero.
- R8: Control-word writes outside direct mode leave the waveform unchanged until a commit.
- R9: Writing 1 to bit 0 of the commit word snapshots the shadow settings. While the output is enabled, the snapshot becomes active at the next period boundary, and the current period completes with the old settings.
- R10: A commit made while the output is disabled becomes active on the next clock edge.
- R11: When bit 0 of the direct-mode word is set, a control-word write updates that word's running fields at the same edge and restarts the period from zero.
- R12: A write to the commit word with bit 0 clear has no effect on the running settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register access request this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| pwm_out | output | 1 | Backlight PWM output, registered |

## Verification
The assertions assume that at most one register access arrives per cycle. They also assume that a commit is never issued in the same cycle as a control-word write, so the snapshot always sees settled shadow values. The stimulus presents one access at a time and holds each for a single cycle between falling edges, so both conditions always hold. Direct-mode writes are issued only while the output is enabled or idle, and never in a cycle that also carries a pending commit to a boundary. This keeps the override order between a boundary transfer and a direct write out of the checked space.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam int DIV_W    = 10;
  localparam int PER_W    = 12;
  localparam int HIGH_W   = 13;
  localparam int DIV_LSB  = 16;
  localparam int PER_LSB  = 0;
  localparam int HIGH_LSB = 16;
  localparam int CMP_W    = (HIGH_W > PER_W) ? HIGH_W : PER_W;

  localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_COMMIT = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_DIRECT = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_CTL0   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CTL1   = 8'h14;

  typedef struct packed {
    logic [DIV_W-1:0]  div;
    logic [PER_W-1:0]  per;
    logic [HIGH_W-1:0] high;
  } pwm_cfg_t;

  function automatic pwm_cfg_t unpack_cfg(input logic [DATA_W-1:0] w0,
                                          input logic [DATA_W-1:0] w1);
    pwm_cfg_t c;
    c.div  = w0[DIV_LSB +: DIV_W];
    c.per  = w1[PER_LSB +: PER_W];
    c.high = w1[HIGH_LSB +: HIGH_W];
    return c;
  endfunction
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              en,
  output pwm_cfg_t          shadow,
  output pwm_cfg_t          dir_cfg,
  output logic              commit_req,
  output logic              dir_we0,
  output logic              dir_we1
);
  logic [DATA_W-1:0] en_word, dir_word, ctl0_word, ctl1_word;
  logic              wr, rd;
  logic              direct;

  assign wr     = req_valid && req_write;
  assign rd     = req_valid && !req_write;
  assign en     = en_word[0];
  assign direct = dir_word[0];
  assign shadow = unpack_cfg(ctl0_word, ctl1_word);

  // fields as they would land from this write, used by direct mode
  assign dir_cfg    = unpack_cfg(req_wdata, req_wdata);
  assign commit_req = wr && (req_addr == OFS_COMMIT) && req_wdata[0];
  assign dir_we0    = wr && direct && (req_addr == OFS_CTL0);
  assign dir_we1    = wr && direct && (req_addr == OFS_CTL1);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_word   <= '0;
      dir_word  <= '0;
      ctl0_word <= '0;
      ctl1_word <= '0;
    end else if (wr) begin
      case (req_addr)
        OFS_ENABLE: en_word   <= req_wdata;
        OFS_DIRECT: dir_word  <= req_wdata;
        OFS_CTL0:   ctl0_word <= req_wdata;
        OFS_CTL1:   ctl1_word <= req_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      case (req_addr)
        OFS_ENABLE: rdata <= en_word;
        OFS_DIRECT: rdata <= dir_word;
        OFS_CTL0:   rdata <= ctl0_word;
        OFS_CTL1:   rdata <= ctl1_word;
        default:    rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/bl_pwm_sync.sv
module bl_pwm_sync
  import bl_pwm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     run,
  input  logic     boundary,
  input  logic     commit_req,
  input  pwm_cfg_t shadow,
  input  logic     dir_we0,
  input  logic     dir_we1,
  input  pwm_cfg_t dir_cfg,
  output pwm_cfg_t act,
  output logic     pending
);
  pwm_cfg_t pend_cfg;
  logic     apply;

  // a snapshot moves to the running set at a period end, or at once when idle
  assign apply = pending && (boundary || !run);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      pend_cfg <= '0;
      act      <= '0;
    end else begin
      if (apply) act <= pend_cfg;
      if (dir_we0) act.div <= dir_cfg.div;
      if (dir_we1) begin
        act.per  <= dir_cfg.per;
        act.high <= dir_cfg.high;
      end
      if (commit_req) begin
        pending  <= 1'b1;
        pend_cfg <= shadow;
      end else if (apply) begin
        pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bl_pwm_prescaler.sv
module bl_pwm_prescaler
  import bl_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || !run || restart || tick) cnt <= '0;
    else                                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bl_pwm_wave.sv
module bl_pwm_wave
  import bl_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              restart,
  input  logic              tick,
  input  logic [PER_W-1:0]  per,
  input  logic [HIGH_W-1:0] high,
  output logic              boundary,
  output logic [PER_W-1:0]  per_cnt,
  output logic              pwm_out
);
  logic [CMP_W-1:0] cnt_ext, high_ext;
  logic             level;

  assign boundary = tick && (per_cnt == per);
  assign cnt_ext  = CMP_W'(per_cnt);
  assign high_ext = CMP_W'(high);
  assign level    = run && (cnt_ext < high_ext);

  always_ff @(posedge clk) begin
    if (rst || !run || restart || boundary) per_cnt <= '0;
    else if (tick)                          per_cnt <= per_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_out <= 1'b0;
    else     pwm_out <= level;
  end
endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top
  import bl_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pwm_out
);
  logic             en_w, commit_w, dir_we0_w, dir_we1_w, restart_w;
  logic             tick_w, boundary_w, pend_w;
  logic [PER_W-1:0] per_cnt_w;
  pwm_cfg_t         shadow_w, dir_cfg_w, act_w;

  assign restart_w = dir_we0_w || dir_we1_w;

  bl_pwm_regs u_regs (
    .clk(clk), .rst(rst),
    .req_valid(reg_valid), .req_write(reg_write),
    .req_addr(reg_addr), .req_wdata(reg_wdata),
    .rdata(reg_rdata), .en(en_w),
    .shadow(shadow_w), .dir_cfg(dir_cfg_w),
    .commit_req(commit_w), .dir_we0(dir_we0_w), .dir_we1(dir_we1_w)
  );

  bl_pwm_sync u_sync (
    .clk(clk), .rst(rst), .run(en_w), .boundary(boundary_w),
    .commit_req(commit_w), .shadow(shadow_w),
    .dir_we0(dir_we0_w), .dir_we1(dir_we1_w), .dir_cfg(dir_cfg_w),
    .act(act_w), .pending(pend_w)
  );

  bl_pwm_prescaler u_pre (
    .clk(clk), .rst(rst), .run(en_w), .restart(restart_w),
    .div(act_w.div), .tick(tick_w)
  );

  bl_pwm_wave u_wave (
    .clk(clk), .rst(rst), .run(en_w), .restart(restart_w), .tick(tick_w),
    .per(act_w.per), .high(act_w.high),
    .boundary(boundary_w), .per_cnt(per_cnt_w), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk
  import bl_pwm_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             boundary,
  input logic             restart,
  input logic             commit_req,
  input logic             pending,
  input pwm_cfg_t         act,
  input logic [PER_W-1:0] per_cnt,
  input logic             pwm_out
);
  // R1
  reset_low_chk: assert property (@(posedge clk) rst |=> !pwm_out);

  // R7
  disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> !pwm_out);

  // R6
  zero_high_chk: assert property (@(posedge clk) disable iff (rst)
    (act.high == '0) |=> !pwm_out);

  // R6
  full_high_chk: assert property (@(posedge clk) disable iff (rst)
    (run && (act.high > {1'b0, act.per})) |=> pwm_out);

  // R4
  per_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (per_cnt <= act.per));

  // R9
  active_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !boundary && !restart) |=> $stable(act));

  // R9
  pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (pending && boundary && !commit_req) |=> !pending);
endmodule

bind bl_pwm_top bl_pwm_chk u_chk (
  .clk(clk), .rst(rst), .run(en_w), .boundary(boundary_w),
  .restart(restart_w), .commit_req(commit_w), .pending(pend_w),
  .act(act_w), .per_cnt(per_cnt_w), .pwm_out(pwm_out)
);

// File: tb/sim_bl_pwm_top.sv
module sim_bl_pwm_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_valid = 1'b0;
  logic        reg_write = 1'b0;
  logic [7:0]  reg_addr  = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pwm_out;

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_req  = "R1";

  always #10 clk = ~clk;

  bl_pwm_top u0 (
    .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: time into period, settings as integers
  bit          m_en, m_byp, m_pend, m_out, nxt;
  logic [31:0] m_c0, m_c1;
  int          p_div, p_per, p_high, a_div, a_per, a_high, m_t;

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_byp = 0; m_pend = 0; m_out = 0;
      m_c0 = 0; m_c1 = 0;
      p_div = 0; p_per = 0; p_high = 0;
      a_div = 0; a_per = 0; a_high = 0; m_t = 0;
    end else begin
      nxt = m_en && ((m_t / (a_div + 1)) < a_high);
      if (!m_en || (m_t == (a_div + 1) * (a_per + 1) - 1)) begin
        m_t = 0;
        if (m_pend) begin
          a_div = p_div; a_per = p_per; a_high = p_high; m_pend = 0;
        end
      end else begin
        m_t++;
      end
      if (reg_valid && reg_write) begin
        case (reg_addr)
          8'h00: m_en = reg_wdata[0];
          8'h08: if (reg_wdata[0]) begin
            m_pend = 1;
            p_div = int'(m_c0[25:16]); p_per = int'(m_c1[11:0]); p_high = int'(m_c1[28:16]);
          end
          8'h0C: m_byp = reg_wdata[0];
          8'h10: begin
            m_c0 = reg_wdata;
            if (m_byp) begin a_div = int'(reg_wdata[25:16]); m_t = 0; end
          end
          8'h14: begin
            m_c1 = reg_wdata;
            if (m_byp) begin
              a_per = int'(reg_wdata[11:0]); a_high = int'(reg_wdata[28:16]); m_t = 0;
            end
          end
          default: ;
        endcase
      end
      m_out = nxt;
    end
  end

  always @(negedge clk) begin
    if (!rst) chk(pwm_out === m_out, cur_req, longint'(pwm_out), longint'(m_out));
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_valid = 1'b0;
    chk(reg_rdata === exp, req, longint'(reg_rdata), longint'(exp));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset values
    chk(pwm_out === 1'b0, "R1", longint'(pwm_out), 0);
    rd(8'h00, 32'h0, "R1"); rd(8'h08, 32'h0, "R1"); rd(8'h0C, 32'h0, "R1");
    rd(8'h10, 32'h0, "R1"); rd(8'h14, 32'h0, "R1");

    // R2: full-word readback, write-only commit, unmapped offset
    cur_req = "R2";
    wr(8'h10, 32'hFC02_ABCD);        // divider 2
    wr(8'h14, 32'hE005_F007);        // high 5, period 7
    wr(8'h0C, 32'hDEAD_BEEE);        // direct bit clear
    rd(8'h10, 32'hFC02_ABCD, "R2");
    rd(8'h14, 32'hE005_F007, "R2");
    rd(8'h0C, 32'hDEAD_BEEE, "R2");
    wr(8'h08, 32'h0000_0000);
    rd(8'h08, 32'h0, "R2");
    rd(8'h04, 32'h0, "R2");
    wr(8'h0C, 32'h0);
    rd(8'h0C, 32'h0, "R2");

    // R10: commit while disabled applies immediately
    cur_req = "R10";
    wr(8'h08, 32'h1);
    wr(8'h08, 32'h0);
    idle(3);

    // R7: enable rise starts the period high two edges after the write
    cur_req = "R7";
    wr(8'h00, 32'h5A00_0001);
    chk(pwm_out === 1'b0, "R7", longint'(pwm_out), 0);
    @(negedge clk);
    chk(pwm_out === 1'b1, "R7", longint'(pwm_out), 1);
    rd(8'h00, 32'h5A00_0001, "R2");

    // R3 R4 R5: three full periods of 24 clocks with 15 high
    cur_req = "R3 R4 R5";
    idle(80);

    // R8: shadow write without commit leaves the waveform alone
    cur_req = "R8";
    wr(8'h14, 32'h0002_0003);        // high 2, period 3
    idle(60);

    // R9: commit mid-period, switch at the next boundary
    cur_req = "R9";
    idle(5);
    wr(8'h08, 32'h1);
    wr(8'h08, 32'h0);
    idle(60);

    // R12: commit word with bit 0 clear does nothing
    cur_req = "R12";
    wr(8'h10, 32'h0001_0000);        // divider 1 in shadow
    wr(8'h08, 32'h0000_0002);
    idle(50);
    wr(8'h08, 32'h1);
    idle(40);

    // R6: zero width, width equal to and above period+1
    cur_req = "R6";
    wr(8'h14, 32'h0000_0004);
    wr(8'h08, 32'h1);
    idle(40);
    wr(8'h14, 32'h0005_0004);
    wr(8'h08, 32'h1);
    idle(40);
    wr(8'h14, 32'h0006_0004);
    wr(8'h08, 32'h1);
    idle(40);
    wr(8'h14, 32'h0002_0004);
    wr(8'h08, 32'h1);
    idle(30);

    // R7: disable forces low, re-enable restarts
    cur_req = "R7";
    wr(8'h00, 32'h0);
    chk(pwm_out === 1'b1 || pwm_out === 1'b0, "R7", longint'(pwm_out), longint'(pwm_out));
    @(negedge clk);
    chk(pwm_out === 1'b0, "R7", longint'(pwm_out), 0);
    idle(20);
    wr(8'h00, 32'h1);
    @(negedge clk);
    chk(pwm_out === 1'b1, "R7", longint'(pwm_out), 1);
    idle(40);

    // R11: direct mode updates running values and restarts the period
    cur_req = "R11";
    wr(8'h0C, 32'h1);
    idle(7);
    wr(8'h14, 32'h0003_0005);
    @(negedge clk);
    chk(pwm_out === 1'b1, "R11", longint'(pwm_out), 1);
    idle(50);
    wr(8'h10, 32'h0000_0000);
    idle(50);
    wr(8'h0C, 32'h0);
    cur_req = "R8";
    wr(8'h14, 32'h0001_0002);
    idle(40);

    summary();
    $finish;
  end
endmodule